// File: doc/BRIEF.md
# Double-Buffered BCD Calendar Clock

This block keeps calendar time as packed BCD in 24-hour form: century, year, month, date, day-of-week, hours, minutes and seconds. A free-running internal counter set advances once per second, where a second is a fixed number of pulses on `tick_in` (parameter `TICKS_PER_SEC`). Software never touches that counter set directly. It sees a second, user-facing copy of the eight values, placed at the eight highest byte addresses of a byte-wide address space.

Two control bits in the century byte steer the copy. With the read bit set, the user copy is frozen so all eight bytes can be read as one consistent snapshot, and the counters keep running underneath. With the write bit set, bus writes fill the user copy only. When the write bit drops, the whole copy is moved into the counters in one clock and the sub-second divider starts over. With both bits clear, the user copy follows the counters each clock.

The bus is a plain single-cycle register port, not a stream. A write (`bus_sel` and `bus_we` high) is taken on every rising edge and is never stalled. Read data is combinational from the address. There is no valid/ready pair and no back-pressure.

Top module: `rtc_calendar`

## Requirements
- R1: The window is every address whose bits above bit 2 are all ones; bits 2:0 select the byte as 7 year, 6 month, 5 date, 4 day, 3 hour, 2 minutes, 1 seconds, 0 century. Unused bits read 0. `bus_rdata` is 0 when `bus_sel` is low or the address is outside the window, and writes outside the window change nothing.
- R2: After reset the bytes read century 0x20, year 0x00, month 0x01, date 0x01, day 0x81 (flag high, dow 1), and hour, minutes and seconds 0x00.
- R3: While counting, seconds advance exactly once per `TICKS_PER_SEC` pulses of `tick_in`.
- R4: Seconds and minutes wrap 0x59 to 0x00 and hours wrap 0x23 to 0x00 with carry. Day-of-week (day byte bits 2:0) advances at midnight and wraps from 7 to 1.
- R5: The date wraps to 0x01 after the month's last day: 0x30 for months 04, 06, 09 and 11, and 0x31 for the other non-February months. February ends at 0x29 when the BCD year is divisible by 4 (00 counts as divisible) and at 0x28 otherwise. Month 0x12 wraps to 0x01 and carries into the year. Year 0x99 wraps to 0x00 and carries into the century, and century 0x39 wraps to 0x00.
- R6: Century byte bit 7 is the write bit and bit 6 is the read bit. A time field is stored only when the write bit, as it stands after that write, is 1. With the write bit at 0, writes to time fields are lost.
- R7: When the write bit falls, the next clock copies all eight user bytes into the counters together and clears the sub-second divider, so a full `TICKS_PER_SEC` pulses are needed before the next second.
- R8: While the read bit is 1 and the write bit is 0, the user bytes keep the values they had when the read bit was set, and the counters keep advancing.
- R9: While both bits are 0, the user bytes follow the counters and show a new count within two clocks.
- R10: Seconds byte bit 7 is the oscillator stop bit. It is always writable. While it is 1, `tick_in` is ignored and the count holds.
- R11: Day byte bit 7 reads `batt_ok` and cannot be written. Day byte bit 6 is the frequency test bit, which is always writable and reads back as written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_in | input | 1 | Sub-second pulse, one clock wide per pulse |
| batt_ok | input | 1 | Battery-good level from the analog monitor |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write qualifier for `bus_sel` |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |

## Verification
A fault in the counter set shows up two clocks after the second it affects, as a wrong byte in the refreshed user copy. That holds only when neither control bit is set; otherwise it stays hidden until the read bit is cleared. A fault in the carry chain stays hidden until the matching boundary, so the bench loads times just before each month, year, century and leap boundary and steps one second across it. Faults in the freeze, load or divider restart appear as a snapshot that drifts, values that fail to arrive after the write bit drops, or a second that lands one pulse early. Each of these is visible on the very next read.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  // Packed so the year sits in the top byte: byte index equals window offset.
  typedef struct packed {
    logic [7:0] year;
    logic [7:0] month;
    logic [7:0] date;
    logic [7:0] dow;
    logic [7:0] hour;
    logic [7:0] mins;
    logic [7:0] secs;
    logic [7:0] cent;
  } cal_t;

  localparam int unsigned NUM_BYTES = 8;
  localparam int unsigned OFS_W     = $clog2(NUM_BYTES);

  localparam logic [OFS_W-1:0] OFS_CENT = 3'd0;
  localparam logic [OFS_W-1:0] OFS_SECS = 3'd1;
  localparam logic [OFS_W-1:0] OFS_DAY  = 3'd4;

  // Bits that carry time data in each byte, indexed by offset.
  localparam logic [NUM_BYTES-1:0][7:0] FIELD_MASK =
    {8'hFF, 8'h1F, 8'h3F, 8'h07, 8'h3F, 8'h7F, 8'h7F, 8'h3F};

  localparam cal_t CAL_RESET = '{year: 8'h00, month: 8'h01, date: 8'h01,
                                 dow: 8'h01, hour: 8'h00, mins: 8'h00,
                                 secs: 8'h00, cent: 8'h20};

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  // Divisible by 4 in BCD: even tens need ones 0/4/8, odd tens need 2/6.
  function automatic logic is_leap(input logic [7:0] y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic logic [7:0] last_day(input logic [7:0] m, input logic [7:0] y);
    case (m)
      8'h02:                      return is_leap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_tick_div.sv
module rtc_tick_div #(
  parameter int unsigned DIV = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic stop,
  input  logic restart,
  output logic sec_pulse
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          at_last;
  logic          step;

  assign at_last   = (cnt_q == LAST);
  assign step      = tick & ~stop & ~restart;
  assign sec_pulse = step & at_last;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) cnt_q <= '0;
    else if (step)         cnt_q <= at_last ? '0 : cnt_q + 1'b1;
  end

  assert_div_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  assert_restart_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));

  assert_stop_freezes_div_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !restart) |=> $stable(cnt_q));

endmodule

// File: rtl/rtc_time_count.sv
module rtc_time_count
  import rtc_cal_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sec_pulse,
  input  logic load,
  input  cal_t load_val,
  output cal_t count
);
  cal_t cur_q;
  cal_t nxt;

  // Carry chain from seconds up to century.
  always_comb begin
    nxt = cur_q;
    if (cur_q.secs != 8'h59) nxt.secs = bcd_inc(cur_q.secs);
    else begin
      nxt.secs = 8'h00;
      if (cur_q.mins != 8'h59) nxt.mins = bcd_inc(cur_q.mins);
      else begin
        nxt.mins = 8'h00;
        if (cur_q.hour != 8'h23) nxt.hour = bcd_inc(cur_q.hour);
        else begin
          nxt.hour = 8'h00;
          nxt.dow  = (cur_q.dow == 8'h07) ? 8'h01 : cur_q.dow + 8'h01;
          if (cur_q.date != last_day(cur_q.month, cur_q.year))
            nxt.date = bcd_inc(cur_q.date);
          else begin
            nxt.date = 8'h01;
            if (cur_q.month != 8'h12) nxt.month = bcd_inc(cur_q.month);
            else begin
              nxt.month = 8'h01;
              if (cur_q.year != 8'h99) nxt.year = bcd_inc(cur_q.year);
              else begin
                nxt.year = 8'h00;
                nxt.cent = (cur_q.cent == 8'h39) ? 8'h00 : bcd_inc(cur_q.cent);
              end
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         cur_q <= CAL_RESET;
    else if (load)      cur_q <= load_val;
    else if (sec_pulse) cur_q <= nxt;
  end

  assign count = cur_q;

  assert_second_moves_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_pulse && !load) |=> (cur_q.secs != $past(cur_q.secs)));

  assert_idle_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_pulse && !load) |=> $stable(cur_q));

  assert_dow_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_pulse && !load && cur_q.dow == 8'h07 && cur_q.hour == 8'h23 &&
     cur_q.mins == 8'h59 && cur_q.secs == 8'h59) |=> (cur_q.dow == 8'h01));

endmodule

// File: rtl/rtc_user_bank.sv
module rtc_user_bank
  import rtc_cal_pkg::*;
#(
  parameter int unsigned ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  cal_t              live,
  input  logic              batt_ok,
  output cal_t              shadow,
  output logic              load,
  output logic              osc_stop
);
  localparam logic [NUM_BYTES-1:0][7:0] RST_B = CAL_RESET;

  logic [NUM_BYTES-1:0][7:0] live_b;
  logic [NUM_BYTES-1:0][7:0] ub;
  logic                      in_win;
  logic [OFS_W-1:0]          ofs;
  logic                      wr;
  logic                      w_bit, r_bit, osc_bit, ft_bit, w_prev;
  logic                      w_next;
  logic                      refresh;
  logic [7:0]                rd_val;

  assign live_b  = live;
  assign in_win  = &addr[ADDR_W-1:OFS_W];
  assign ofs     = addr[OFS_W-1:0];
  assign wr      = sel & we & in_win;
  assign w_next  = (wr && ofs == OFS_CENT) ? wdata[7] : w_bit;
  assign load    = w_prev & ~w_bit;
  assign refresh = ~w_bit & ~r_bit & ~load;

  // One holding byte per window location.
  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
    logic [7:0] byte_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                       byte_q <= RST_B[i] & FIELD_MASK[i];
      else if (wr && ofs == OFS_W'(i) && w_next)        byte_q <= wdata & FIELD_MASK[i];
      else if (refresh)                                 byte_q <= live_b[i] & FIELD_MASK[i];
    end
    assign ub[i] = byte_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      w_bit   <= 1'b0;
      r_bit   <= 1'b0;
      osc_bit <= 1'b0;
      ft_bit  <= 1'b0;
      w_prev  <= 1'b0;
    end else begin
      w_prev <= w_bit;
      if (wr && ofs == OFS_CENT) begin
        w_bit <= wdata[7];
        r_bit <= wdata[6];
      end
      if (wr && ofs == OFS_SECS) osc_bit <= wdata[7];
      if (wr && ofs == OFS_DAY)  ft_bit  <= wdata[6];
    end
  end

  always_comb begin
    case (ofs)
      OFS_CENT: rd_val = {w_bit, r_bit, ub[OFS_CENT][5:0]};
      OFS_SECS: rd_val = {osc_bit, ub[OFS_SECS][6:0]};
      OFS_DAY:  rd_val = {batt_ok, ft_bit, ub[OFS_DAY][5:0]};
      default:  rd_val = ub[ofs];
    endcase
  end

  assign rdata    = (sel && in_win) ? rd_val : 8'h00;
  assign shadow   = ub;
  assign osc_stop = osc_bit;

  assert_freeze_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (r_bit && !w_bit && !wr) |=> $stable(ub));

  assert_refresh_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh && !wr) |=> (ub == $past(live_b & FIELD_MASK)));

  assert_load_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !load);

  assert_no_field_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !w_next && !refresh) |=> $stable(ub));

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
#(
  parameter int unsigned ADDR_W        = 19,
  parameter int unsigned TICKS_PER_SEC = 32768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_in,
  input  logic              batt_ok,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata
);
  cal_t count;
  cal_t shadow;
  logic load;
  logic osc_stop;
  logic sec_pulse;

  rtc_tick_div #(.DIV(TICKS_PER_SEC)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick_in),
    .stop      (osc_stop),
    .restart   (load),
    .sec_pulse (sec_pulse)
  );

  rtc_time_count u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .sec_pulse (sec_pulse),
    .load      (load),
    .load_val  (shadow),
    .count     (count)
  );

  rtc_user_bank #(.ADDR_W(ADDR_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (bus_sel),
    .we       (bus_we),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .rdata    (bus_rdata),
    .live     (count),
    .batt_ok  (batt_ok),
    .shadow   (shadow),
    .load     (load),
    .osc_stop (osc_stop)
  );

  assert_stop_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_stop && !load) |=> $stable(count));

  assert_load_copies_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count == $past(shadow)));

endmodule

// File: tb/rtc_calendar_test.sv
module rtc_calendar_test;
  localparam int unsigned AW  = 19;
  localparam int unsigned DIV = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick_in = 1'b0;
  logic          batt_ok = 1'b1;
  logic          bus_sel = 1'b0;
  logic          bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0]    bus_wdata = '0;
  logic [7:0]    bus_rdata;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  rtc_calendar #(.ADDR_W(AW), .TICKS_PER_SEC(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .batt_ok(batt_ok),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] ofs, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = {{(AW-3){1'b1}}, ofs}; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] ofs, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = {{(AW-3){1'b1}}, ofs};
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_in = 1'b1;
    end
    @(negedge clk); tick_in = 1'b0;
    settle();
  endtask

  task automatic set_time(input logic [7:0] c, y, mo, d, dw, h, mi, s);
    wr(3'd0, 8'h80 | c);
    wr(3'd7, y); wr(3'd6, mo); wr(3'd5, d); wr(3'd4, dw);
    wr(3'd3, h); wr(3'd2, mi); wr(3'd1, s);
    wr(3'd0, 8'h00);
    settle();
  endtask

  task automatic expect_time(input string req, input logic [7:0] c, y, mo, d, dw, h, mi, s);
    logic [7:0] v;
    rd(3'd0, v); chk({req, " century"}, v, c);
    rd(3'd7, v); chk({req, " year"}, v, y);
    rd(3'd6, v); chk({req, " month"}, v, mo);
    rd(3'd5, v); chk({req, " date"}, v, d);
    rd(3'd4, v); chk({req, " day"}, v, {1'b1, 1'b0, 3'b000, dw[2:0]});
    rd(3'd3, v); chk({req, " hour"}, v, h);
    rd(3'd2, v); chk({req, " minutes"}, v, mi);
    rd(3'd1, v); chk({req, " seconds"}, v, s);
  endtask

  task automatic t_reset();
    expect_time("R2 reset", 8'h20, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00);
  endtask

  task automatic t_load_and_roll();
    set_time(8'h20, 8'h23, 8'h02, 8'h28, 8'h07, 8'h23, 8'h59, 8'h58);
    expect_time("R7 load", 8'h20, 8'h23, 8'h02, 8'h28, 8'h07, 8'h23, 8'h59, 8'h58);
    ticks(DIV);
    expect_time("R4 sec", 8'h20, 8'h23, 8'h02, 8'h28, 8'h07, 8'h23, 8'h59, 8'h59);
    ticks(DIV);
    expect_time("R5 feb28 non-leap", 8'h20, 8'h23, 8'h03, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00);
  endtask

  task automatic t_calendar();
    set_time(8'h20, 8'h24, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59);
    ticks(DIV);
    expect_time("R5 leap 24", 8'h20, 8'h24, 8'h02, 8'h29, 8'h04, 8'h00, 8'h00, 8'h00);
    set_time(8'h20, 8'h24, 8'h02, 8'h29, 8'h04, 8'h23, 8'h59, 8'h59);
    ticks(DIV);
    expect_time("R5 feb29 end", 8'h20, 8'h24, 8'h03, 8'h01, 8'h05, 8'h00, 8'h00, 8'h00);
    set_time(8'h21, 8'h00, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59);
    ticks(DIV);
    expect_time("R5 year00 leap", 8'h21, 8'h00, 8'h02, 8'h29, 8'h03, 8'h00, 8'h00, 8'h00);
    set_time(8'h20, 8'h31, 8'h04, 8'h30, 8'h06, 8'h23, 8'h59, 8'h59);
    ticks(DIV);
    expect_time("R5 30-day month", 8'h20, 8'h31, 8'h05, 8'h01, 8'h07, 8'h00, 8'h00, 8'h00);
    set_time(8'h20, 8'h99, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h59);
    ticks(DIV);
    expect_time("R5 R4 century carry", 8'h21, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00);
    set_time(8'h39, 8'h99, 8'h12, 8'h31, 8'h02, 8'h23, 8'h59, 8'h59);
    ticks(DIV);
    expect_time("R5 century wrap", 8'h00, 8'h00, 8'h01, 8'h01, 8'h03, 8'h00, 8'h00, 8'h00);
  endtask

  task automatic t_divider();
    logic [7:0] v;
    set_time(8'h20, 8'h10, 8'h06, 8'h15, 8'h02, 8'h08, 8'h00, 8'h00);
    ticks(2);
    set_time(8'h20, 8'h10, 8'h06, 8'h15, 8'h02, 8'h08, 8'h00, 8'h00);
    ticks(DIV - 1);
    rd(3'd1, v); chk("R7 divider restart", v, 8'h00);
    ticks(1);
    rd(3'd1, v); chk("R3 one second per DIV ticks", v, 8'h01);
  endtask

  task automatic t_freeze();
    logic [7:0] v;
    set_time(8'h20, 8'h10, 8'h06, 8'h15, 8'h02, 8'h10, 8'h00, 8'h00);
    wr(3'd0, 8'h40);
    ticks(3 * DIV);
    rd(3'd1, v); chk("R8 frozen seconds", v, 8'h00);
    rd(3'd0, v); chk("R8 read bit visible", v, 8'h60);
    wr(3'd0, 8'h00);
    settle();
    rd(3'd1, v); chk("R9 refresh after clear", v, 8'h03);
  endtask

  task automatic t_ignore_and_stop();
    logic [7:0] v;
    set_time(8'h20, 8'h10, 8'h06, 8'h15, 8'h02, 8'h11, 8'h20, 8'h30);
    wr(3'd2, 8'h45);
    settle();
    rd(3'd2, v); chk("R6 write without write bit lost", v, 8'h20);
    wr(3'd1, 8'h80);
    settle();
    rd(3'd1, v); chk("R10 stop bit reads back", v, 8'hB0);
    ticks(2 * DIV);
    rd(3'd1, v); chk("R10 count holds while stopped", v, 8'hB0);
    wr(3'd1, 8'h00);
    ticks(DIV);
    rd(3'd1, v); chk("R10 resumes", v, 8'h31);
  endtask

  task automatic t_flags();
    logic [7:0] v;
    set_time(8'h20, 8'h10, 8'h06, 8'h15, 8'h05, 8'h12, 8'h00, 8'h00);
    batt_ok = 1'b0;
    rd(3'd4, v); chk("R11 battery low", v, 8'h05);
    wr(3'd4, 8'hC0);
    settle();
    rd(3'd4, v); chk("R11 test bit set, flag unwritable", v, 8'h45);
    batt_ok = 1'b1;
    rd(3'd4, v); chk("R11 battery good", v, 8'hC5);
    wr(3'd4, 8'h00);
    settle();
    rd(3'd4, v); chk("R11 test bit clear", v, 8'h85);
  endtask

  task automatic t_window();
    logic [7:0] v;
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = {{(AW-4){1'b1}}, 1'b0, 3'd1};
    #1 v = bus_rdata; bus_sel = 1'b0;
    chk("R1 outside window reads 0", v, 8'h00);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = {{(AW-3){1'b0}}, 3'd1}; bus_wdata = 8'h80;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    rd(3'd1, v); chk("R1 outside write ignored", v[7:7], 1'b0);
    @(negedge clk);
    bus_sel = 1'b0; bus_addr = {{(AW-3){1'b1}}, 3'd7};
    #1 chk("R1 no select reads 0", bus_rdata, 8'h00);
    rd(3'd6, v); chk("R1 month unused bits zero", v & 8'hE0, 8'h00);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load_and_roll();
    t_calendar();
    t_divider();
    t_freeze();
    t_ignore_and_stop();
    t_flags();
    t_window();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hung expected done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule